// File: doc/BRIEF.md
# Instrument Status Byte Service-Request Logic

This block gathers the status of a remotely controlled instrument into one status byte and decides when the instrument should ask its controller for attention. Two sticky event registers collect strobes: one for general instrument events (power-up, faults, completion and so on) and one for readiness events. Each has its own enable mask, and each reduces to one summary bit in the status byte. Two live flags from the reply queue and the error queue also feed the status byte.

A service-request enable mask picks which status byte bits may raise a request. The master summary is the live OR of the enabled bits. The service-request output is raised when that summary goes from clear to set. Bit 6 of the status byte has two views. On the query view it is the live master summary. On the serial-poll view it is the request flag itself, which the poll clears.

The surrounding message parser writes the masks, reads the registers, and issues poll strobes. Queue storage and the bus handshake live outside this block.

Top module: `stb_srq_core`

## Requirements
- R1: After reset, the general event register reads 0x80 (power-up bit 7 set, all others clear). The readiness event register, all three enable masks and `srq_o` all read 0.
- R2: General event bit positions are: 7 power-up, 6 user request, 5 command error, 4 execution error, 3 device fault, 2 query error, 1 control request, 0 operation done. A strobe sets its bit, and the bit stays set. A read strobe clears all bits at the next edge. A bit strobed in the same cycle as the read stays set.
- R3: The readiness event register uses bit 2 for measurement, bit 1 for not-ready and bit 0 for ready. These bits are sticky and cleared by read, like R2. Bits 7..3 always read 0. Its enable mask keeps only bits 2..0, so writing 0xFF reads back 0x07.
- R4: The status byte carries five live bits. Bit 5 is set when any general event bit matches its enable bit. Bit 4 follows the reply-queue-not-empty flag. Bit 2 follows the error-queue-not-empty flag. Bit 0 is set when any readiness event bit matches its enable bit. Bits 7, 3 and 1 read 0.
- R5: The service-request enable mask keeps only bits 5, 4, 2 and 0. Writing 0xFF reads back 0x35, so bit 6 can never raise a request. Writing 0x14 lets only the two queue flags raise a request.
- R6: Query-view bit 6 (the master summary) is set exactly when some status byte bit is set together with its enable bit. It clears as soon as those causes clear.
- R7: `srq_o` rises one cycle after the master summary rises. Poll-view bit 6 equals `srq_o`. The other poll-view bits match the query view.
- R8: A serial-poll strobe clears `srq_o` and poll-view bit 6 at the next edge. If the master summary stays set, they stay clear until the summary falls and rises again.
- R9: `srq_o` clears at the edge after the master summary falls.
- R10: The general event enable mask stores and reads back all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_evt_set | input | 8 | General event strobes, one per bit |
| rdy_evt_set | input | 3 | Readiness event strobes (measurement, not-ready, ready) |
| outq_nonempty | input | 1 | Reply queue holds at least one message |
| errq_nonempty | input | 1 | Error queue holds at least one entry |
| std_evt_rd | input | 1 | Read strobe: clears the general event register |
| std_en_wr | input | 1 | Write strobe for the general enable mask |
| std_en_data | input | 8 | General enable mask write data |
| rdy_evt_rd | input | 1 | Read strobe: clears the readiness event register |
| rdy_en_wr | input | 1 | Write strobe for the readiness enable mask |
| rdy_en_data | input | 8 | Readiness enable mask write data |
| sre_wr | input | 1 | Write strobe for the service-request enable mask |
| sre_data | input | 8 | Service-request enable mask write data |
| spoll | input | 1 | Serial-poll strobe |
| std_evt_q | output | 8 | General event register contents |
| std_en_q | output | 8 | General enable mask |
| rdy_evt_q | output | 8 | Readiness event register contents |
| rdy_en_q | output | 8 | Readiness enable mask |
| sre_q | output | 8 | Service-request enable mask |
| stb_query | output | 8 | Status byte, query view (bit 6 = master summary) |
| stb_poll | output | 8 | Status byte, poll view (bit 6 = request flag) |
| srq_o | output | 1 | Service-request output |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- general event bits never drop without a read;
- the reply-queue bit tracks its flag;
- every rise of the request has a master summary behind it;
- the request drops once the summary is low, or after a poll that does not coincide with a new rise.

Other behaviour needs a scenario: the exact bit layout under mask combinations, the read-back values of partly implemented masks, the read-versus-strobe collision, and the full request sequence of rise, poll, suppressed re-request and re-arm. The bench covers these with its stimulus table and directed sequences.

// File: rtl/stb_srq_pkg.sv
package stb_srq_pkg;
  localparam int REG_W  = 8;
  localparam int RDY_N  = 3;
  // status byte positions
  localparam int SB_RSR = 0;
  localparam int SB_ERR = 2;
  localparam int SB_MAV = 4;
  localparam int SB_ESB = 5;
  localparam int SB_RQ  = 6;
  // general event power-up position
  localparam int EV_PWR = 7;
  localparam logic [REG_W-1:0] SRE_IMPL  = 8'h35;
  localparam logic [REG_W-1:0] STD_IMPL  = 8'hFF;
  localparam logic [REG_W-1:0] STD_RST   = 8'h80;
  localparam logic [REG_W-1:0] RDY_IMPL  = 8'h07;
  localparam logic [REG_W-1:0] RDY_RST   = 8'h00;
endpackage

// File: rtl/stb_rst_sync.sv
module stb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_r[STAGES-1];
endmodule

// File: rtl/evt_latch_reg.sv
module evt_latch_reg #(
  parameter int               W       = 8,
  parameter logic [W-1:0]     IMPL    = '1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strobe,
  input  logic         rd_clr,
  input  logic         en_wr,
  input  logic [W-1:0] en_data,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] en_q,
  output logic         summary
);
  logic [W-1:0] en_r, en_nxt;

  // enable mask: only implemented positions hold state
  always_comb begin
    en_nxt = en_r;
    if (en_wr) en_nxt = en_data & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_r <= '0;
    else        en_r <= en_nxt;
  end

  // sticky event bits, one flop per implemented position
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic bit_r, bit_nxt;
      always_comb begin
        bit_nxt = bit_r;
        if (rd_clr)    bit_nxt = 1'b0;
        if (strobe[i]) bit_nxt = 1'b1;   // a new event beats the clear
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_r <= RST_VAL[i];
        else        bit_r <= bit_nxt;
      end
      assign evt_q[i] = bit_r;
    end else begin : g_none
      assign evt_q[i] = 1'b0;
    end
  end

  assign en_q    = en_r;
  assign summary = |(evt_q & en_r);
endmodule

// File: rtl/stb_srq_ctrl.sv
module stb_srq_ctrl
  import stb_srq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             esb,
  input  logic             rsr,
  input  logic             outq_nonempty,
  input  logic             errq_nonempty,
  input  logic             spoll,
  input  logic             sre_wr,
  input  logic [REG_W-1:0] sre_data,
  output logic [REG_W-1:0] sre_q,
  output logic [REG_W-1:0] stb_query,
  output logic [REG_W-1:0] stb_poll,
  output logic             srq_o
);
  logic [REG_W-1:0] sre_r, sre_nxt;
  logic [REG_W-1:0] stb_base;
  logic             mss, mss_d, mss_rise;
  logic             srq_r, srq_nxt;

  always_comb begin
    stb_base         = '0;
    stb_base[SB_ESB] = esb;
    stb_base[SB_MAV] = outq_nonempty;
    stb_base[SB_ERR] = errq_nonempty;
    stb_base[SB_RSR] = rsr;
  end

  always_comb begin
    sre_nxt = sre_r;
    if (sre_wr) sre_nxt = sre_data & SRE_IMPL;
  end

  assign mss      = |(stb_base & sre_r);
  assign mss_rise = mss & ~mss_d;

  always_comb begin
    srq_nxt = srq_r;
    if (spoll || !mss) srq_nxt = 1'b0;
    if (mss_rise)      srq_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sre_r <= '0;
      mss_d <= 1'b0;
      srq_r <= 1'b0;
    end else begin
      sre_r <= sre_nxt;
      mss_d <= mss;
      srq_r <= srq_nxt;
    end
  end

  always_comb begin
    stb_query        = stb_base;
    stb_query[SB_RQ] = mss;
    stb_poll         = stb_base;
    stb_poll[SB_RQ]  = srq_r;
  end

  assign sre_q = sre_r;
  assign srq_o = srq_r;
endmodule

// File: rtl/stb_srq_core.sv
module stb_srq_core
  import stb_srq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] std_evt_set,
  input  logic [RDY_N-1:0] rdy_evt_set,
  input  logic             outq_nonempty,
  input  logic             errq_nonempty,
  input  logic             std_evt_rd,
  input  logic             std_en_wr,
  input  logic [REG_W-1:0] std_en_data,
  input  logic             rdy_evt_rd,
  input  logic             rdy_en_wr,
  input  logic [REG_W-1:0] rdy_en_data,
  input  logic             sre_wr,
  input  logic [REG_W-1:0] sre_data,
  input  logic             spoll,
  output logic [REG_W-1:0] std_evt_q,
  output logic [REG_W-1:0] std_en_q,
  output logic [REG_W-1:0] rdy_evt_q,
  output logic [REG_W-1:0] rdy_en_q,
  output logic [REG_W-1:0] sre_q,
  output logic [REG_W-1:0] stb_query,
  output logic [REG_W-1:0] stb_poll,
  output logic             srq_o
);
  logic             rst_n_s;
  logic             esb, rsr;
  logic [REG_W-1:0] rdy_strobe;

  assign rdy_strobe = {{(REG_W-RDY_N){1'b0}}, rdy_evt_set};

  stb_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  evt_latch_reg #(.W(REG_W), .IMPL(STD_IMPL), .RST_VAL(STD_RST)) std_i (
    .clk(clk), .rst_n(rst_n_s), .strobe(std_evt_set), .rd_clr(std_evt_rd),
    .en_wr(std_en_wr), .en_data(std_en_data),
    .evt_q(std_evt_q), .en_q(std_en_q), .summary(esb)
  );

  evt_latch_reg #(.W(REG_W), .IMPL(RDY_IMPL), .RST_VAL(RDY_RST)) rdy_i (
    .clk(clk), .rst_n(rst_n_s), .strobe(rdy_strobe), .rd_clr(rdy_evt_rd),
    .en_wr(rdy_en_wr), .en_data(rdy_en_data),
    .evt_q(rdy_evt_q), .en_q(rdy_en_q), .summary(rsr)
  );

  stb_srq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n_s), .esb(esb), .rsr(rsr),
    .outq_nonempty(outq_nonempty), .errq_nonempty(errq_nonempty),
    .spoll(spoll), .sre_wr(sre_wr), .sre_data(sre_data),
    .sre_q(sre_q), .stb_query(stb_query), .stb_poll(stb_poll), .srq_o(srq_o)
  );
endmodule

// File: rtl/stb_srq_chk.sv
module stb_srq_chk
  import stb_srq_pkg::*;
(
  input logic             clk,
  input logic             rst_n_s,
  input logic             spoll,
  input logic             std_evt_rd,
  input logic             outq_nonempty,
  input logic [REG_W-1:0] std_evt_q,
  input logic [REG_W-1:0] stb_query,
  input logic             srq_o
);
  // R2: general event bits never drop without a read
  a_r2_sticky_events: assert property (@(posedge clk) disable iff (!rst_n_s)
    !std_evt_rd |=> ((std_evt_q & $past(std_evt_q)) == $past(std_evt_q)));

  // R4: reply-queue bit follows its flag
  a_r4_mav_follows: assert property (@(posedge clk) disable iff (!rst_n_s)
    stb_query[SB_MAV] == outq_nonempty);

  // R7: a request only rises behind a set master summary
  a_r7_rise_needs_mss: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(srq_o) |-> $past(stb_query[SB_RQ]));

  // R8: a poll without a fresh summary rise drops the request
  a_r8_poll_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (spoll && !(stb_query[SB_RQ] && !$past(stb_query[SB_RQ]))) |=> !srq_o);

  // R9: a low master summary drops the request next cycle
  a_r9_mss_low_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    !stb_query[SB_RQ] |=> !srq_o);
endmodule

bind stb_srq_core stb_srq_chk chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .spoll(spoll), .std_evt_rd(std_evt_rd),
  .outq_nonempty(outq_nonempty), .std_evt_q(std_evt_q),
  .stb_query(stb_query), .srq_o(srq_o)
);

// File: tb/stb_srq_core_tb_top.sv
module stb_srq_core_tb_top;
  localparam int CLK_P    = 10;
  localparam int WDOG_CYC = 20000;
  localparam int NVEC     = 8;
  // {outq, errq, sre[7:0], expected query byte[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h00, 8'h10},
    {1'b1, 1'b1, 8'h00, 8'h14},
    {1'b1, 1'b0, 8'h14, 8'h50},
    {1'b0, 1'b1, 8'h14, 8'h44},
    {1'b0, 1'b1, 8'h10, 8'h04},
    {1'b1, 1'b1, 8'hFF, 8'h54},
    {1'b0, 1'b0, 8'hFF, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] std_evt_set = '0;
  logic [2:0] rdy_evt_set = '0;
  logic       outq_nonempty = 1'b0, errq_nonempty = 1'b0;
  logic       std_evt_rd = 1'b0, std_en_wr = 1'b0, rdy_evt_rd = 1'b0;
  logic       rdy_en_wr = 1'b0, sre_wr = 1'b0, spoll = 1'b0;
  logic [7:0] std_en_data = '0, rdy_en_data = '0, sre_data = '0;
  logic [7:0] std_evt_q, std_en_q, rdy_evt_q, rdy_en_q, sre_q;
  logic [7:0] stb_query, stb_poll;
  logic       srq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stb_srq_core dut_i (
    .clk(clk), .rst_n(rst_n), .std_evt_set(std_evt_set), .rdy_evt_set(rdy_evt_set),
    .outq_nonempty(outq_nonempty), .errq_nonempty(errq_nonempty),
    .std_evt_rd(std_evt_rd), .std_en_wr(std_en_wr), .std_en_data(std_en_data),
    .rdy_evt_rd(rdy_evt_rd), .rdy_en_wr(rdy_en_wr), .rdy_en_data(rdy_en_data),
    .sre_wr(sre_wr), .sre_data(sre_data), .spoll(spoll),
    .std_evt_q(std_evt_q), .std_en_q(std_en_q), .rdy_evt_q(rdy_evt_q),
    .rdy_en_q(rdy_en_q), .sre_q(sre_q), .stb_query(stb_query),
    .stb_poll(stb_poll), .srq_o(srq_o)
  );

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_sre(input logic [7:0] d);
    sre_wr = 1'b1; sre_data = d; tick(); sre_wr = 1'b0;
  endtask

  task automatic wr_std_en(input logic [7:0] d);
    std_en_wr = 1'b1; std_en_data = d; tick(); std_en_wr = 1'b0;
  endtask

  task automatic rd_std();
    std_evt_rd = 1'b1; tick(); std_evt_rd = 1'b0;
  endtask

  task automatic ev_std(input logic [7:0] s);
    std_evt_set = s; tick(); std_evt_set = '0;
  endtask

  initial begin : watchdog
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    check("R1 std_evt", std_evt_q, 8'h80);
    check("R1 rdy_evt", rdy_evt_q, 8'h00);
    check("R1 std_en",  std_en_q,  8'h00);
    check("R1 rdy_en",  rdy_en_q,  8'h00);
    check("R1 sre",     sre_q,     8'h00);
    check("R1 srq",     {7'd0, srq_o}, 8'h00);

    // R4 R5 R6: status byte table walk
    for (int i = 0; i < NVEC; i++) begin
      wr_sre(VEC[i][15:8]);
      outq_nonempty = VEC[i][17];
      errq_nonempty = VEC[i][16];
      #1;
      check("R4/R6 stb_query vector", stb_query, VEC[i][7:0]);
    end
    outq_nonempty = 1'b0; errq_nonempty = 1'b0;

    // R5: implemented enable bits
    wr_sre(8'hFF);
    check("R5 sre readback", sre_q, 8'h35);
    wr_sre(8'h00);

    // R10: full general enable mask
    wr_std_en(8'hA5);
    check("R10 std_en readback", std_en_q, 8'hA5);
    wr_std_en(8'h00);

    // R3: readiness register
    rdy_en_wr = 1'b1; rdy_en_data = 8'hFF; tick(); rdy_en_wr = 1'b0;
    check("R3 rdy_en readback", rdy_en_q, 8'h07);
    rdy_evt_set = 3'b100; tick(); rdy_evt_set = '0;
    tick();
    check("R3 rdy_evt measurement", rdy_evt_q, 8'h04);
    check("R4 stb bit0 ready summary", stb_query & 8'h01, 8'h01);
    rdy_evt_rd = 1'b1; tick(); rdy_evt_rd = 1'b0;
    check("R3 rdy_evt cleared", rdy_evt_q, 8'h00);

    // R2: sticky and read-vs-strobe collision
    rd_std();
    check("R2 read clears power-up", std_evt_q, 8'h00);
    ev_std(8'h10);
    tick();
    check("R2 exec error held", std_evt_q, 8'h10);
    std_evt_rd = 1'b1; std_evt_set = 8'h01; tick();
    std_evt_rd = 1'b0; std_evt_set = '0;
    check("R2 strobe beats read", std_evt_q, 8'h01);
    rd_std();

    // R4: event summary
    wr_std_en(8'h10);
    ev_std(8'h10);
    check("R4 esb bit5", stb_query & 8'h20, 8'h20);
    rd_std();

    // R7 R8 R9: request sequence via event summary
    wr_sre(8'h20);
    ev_std(8'h10);
    check("R6 mss live", stb_query & 8'h40, 8'h40);
    check("R7 srq not yet", {7'd0, srq_o}, 8'h00);
    tick();
    check("R7 srq raised", {7'd0, srq_o}, 8'h01);
    check("R7 poll bit6", stb_poll, 8'h60);
    spoll = 1'b1; tick(); spoll = 1'b0;
    check("R8 srq cleared by poll", {7'd0, srq_o}, 8'h00);
    check("R8 poll bit6 cleared", stb_poll, 8'h20);
    check("R8 mss stays", stb_query, 8'h60);
    repeat (3) tick();
    check("R8 no re-request", {7'd0, srq_o}, 8'h00);
    rd_std();
    check("R6 mss falls", stb_query, 8'h00);
    tick();
    ev_std(8'h10);
    tick();
    check("R8 re-armed request", {7'd0, srq_o}, 8'h01);
    rd_std();
    check("R9 srq still high", {7'd0, srq_o}, 8'h01);
    tick();
    check("R9 srq dropped", {7'd0, srq_o}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule